// File: doc/BRIEF.md
# Gated Interval Timer Front End

This block is a 16-bit up-counter whose increments can be qualified by a conditioned gate signal. The gate comes from an external pin or from one of two comparator outputs. Each comparator path can pass through a short synchronizer clocked by the timer clock, or it can skip the synchronizer and act as soon as its level changes. After the source multiplexer, a polarity select decides which level counts as active.

Two optional stages shape the gate further. The toggle stage turns each active-going edge into a change of state, so the counter runs from one rising edge to the next and measures a whole period rather than one level. The single-pulse stage is armed by software and lets through exactly one gate event. It then disarms itself. When both stages are enabled together, one full period is captured.

The conditioned gate level can always be read back. Its falling edge sets a sticky event flag, and that flag raises an interrupt request when the request is enabled. The gate level and the event flag both work whether or not gating is applied to the counter.

Top module: `tgate_unit`

## Requirements
- R1: While rst_n is low, count is 0 and irq_flag, irq_req and sp_armed are 0.
- R2: With gate_en low, count increases by one on every clock edge where tick_en is high and holds otherwise. It wraps from all ones to zero.
- R3: With gate_en high, count increases only on edges where tick_en is high and the conditioned gate is active. A plain pin pulse that is active for w cycles adds exactly w counts.
- R4: gate_inv = 1 makes a low level of the selected source the active level.
- R5: gate_src selects the gate source: 0 and 3 select gate_pin, 1 selects cmp_in[0], 2 selects cmp_in[1]. Sources that are not selected have no effect on count.
- R6: With cmp_sync_en[i] = 1, a change on cmp_in[i] reaches gate_val after two clock edges. With cmp_sync_en[i] = 0, it reaches gate_val within the same cycle. The synchronizer delays a pulse but does not change how many counts it produces.
- R7: With tog_en = 1, the gate is active from one active-going edge of the polarity-corrected source to the next. A period of P cycles adds exactly P counts.
- R8: While tog_en is 0, the toggle state is forced and held at 0. If tog_en is then set again, gate_val starts at 0.
- R9: With sp_en = 1, a strobe on sp_go_set sets sp_armed. The next gate pulse is counted in full. sp_armed clears at that pulse's trailing edge, and later pulses add nothing until sp_armed is set again.
- R10: Clearing sp_en clears sp_armed. A pulse that arrives after sp_en is re-enabled, without re-arming, adds nothing.
- R11: With tog_en and sp_en both set and the unit armed, exactly one full gate period is counted, however many periods follow.
- R12: gate_val shows the conditioned gate level, and its falling edge sets irq_flag, even while gate_en is 0.
- R13: irq_flag stays set until an irq_clr strobe. A falling edge of gate_val in the same cycle as irq_clr leaves the flag set. irq_req is high exactly when irq_flag and irq_en are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Increment enable for this cycle |
| gate_pin | input | 1 | External gate input |
| cmp_in | input | 2 | Comparator outputs used as gate sources |
| cmp_sync_en | input | 2 | Per-comparator synchronizer enable |
| gate_src | input | 2 | Gate source select |
| gate_inv | input | 1 | Gate polarity, 1 = active low |
| gate_en | input | 1 | Apply the gate to the counter |
| tog_en | input | 1 | Toggle (full period) mode enable |
| sp_en | input | 1 | Single-pulse mode enable |
| sp_go_set | input | 1 | Strobe that arms single-pulse capture |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq_flag |
| irq_en | input | 1 | Interrupt request enable |
| count | output | 16 | Counter value |
| gate_val | output | 1 | Live conditioned gate level |
| sp_armed | output | 1 | Single-pulse armed status |
| irq_flag | output | 1 | Sticky gate event flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The event flag can be set by a falling edge of the gate and cleared by software in the same cycle. The bench provokes this by dropping the gate pin in the same cycle that it pulses irq_clr. After the next edge it expects the flag to be still set, and once the gate has stayed low it expects a second clear to work. The trailing edge that disarms single-pulse capture and a new arming strobe can also coincide. The bench keeps those two apart and judges capture only by the count deltas it computes from pulse widths and periods.

// File: rtl/tgate_pkg.sv
package tgate_pkg;

  typedef enum logic [1:0] {
    SRC_PIN     = 2'd0,
    SRC_CMP_A   = 2'd1,
    SRC_CMP_B   = 2'd2,
    SRC_PIN_ALT = 2'd3
  } gate_src_e;

  // Edge helpers shared by the gate stages and the event logic.
  function automatic logic rise_of(input logic now, input logic prev);
    return now & ~prev;
  endfunction

  function automatic logic fall_of(input logic now, input logic prev);
    return ~now & prev;
  endfunction

endpackage

// File: rtl/tgate_sync.sv
module tgate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic sync_en,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= (chain << 1) | STAGES'(d);
  end

  // Bypass keeps the source asynchronous to the timer clock.
  assign q = sync_en ? chain[STAGES-1] : d;
endmodule

// File: rtl/tgate_cond.sv
module tgate_cond
  import tgate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] gate_src,
  input  logic       pin,
  input  logic [1:0] cmp_q,
  input  logic       gate_inv,
  input  logic       tog_en,
  input  logic       sp_en,
  input  logic       sp_go_set,
  output logic       gate_final,
  output logic       sp_armed
);
  logic src_raw, pol, pol_d, rise_p;
  logic tog_q, t_lvl, t_d, rise_t, fall_t;
  logic sp_run, sp_live;

  always_comb begin
    case (gate_src_e'(gate_src))
      SRC_CMP_A: src_raw = cmp_q[0];
      SRC_CMP_B: src_raw = cmp_q[1];
      default:   src_raw = pin;
    endcase
  end

  assign pol    = src_raw ^ gate_inv;
  assign rise_p = rise_of(pol, pol_d);

  // Toggle stage: flips on each active-going edge, forced clear when off.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_d <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      pol_d <= pol;
      if (!tog_en)     tog_q <= 1'b0;
      else if (rise_p) tog_q <= ~tog_q;
    end
  end

  assign t_lvl  = tog_en ? tog_q : pol;
  assign rise_t = rise_of(t_lvl, t_d);
  assign fall_t = fall_of(t_lvl, t_d);

  // Single-pulse stage: armed by software, opens on a leading edge,
  // closes and disarms on the trailing edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_d      <= 1'b0;
      sp_run   <= 1'b0;
      sp_armed <= 1'b0;
    end else begin
      t_d <= t_lvl;
      if (!sp_en)                    sp_run <= 1'b0;
      else if (fall_t)               sp_run <= 1'b0;
      else if (sp_armed && rise_t)   sp_run <= 1'b1;
      if (!sp_en)                    sp_armed <= 1'b0;
      else if (sp_go_set)            sp_armed <= 1'b1;
      else if (sp_run && fall_t)     sp_armed <= 1'b0;
    end
  end

  assign sp_live    = sp_run | (sp_armed & rise_t);
  assign gate_final = sp_en ? (t_lvl & sp_live) : t_lvl;

  a_r8_toggle_held_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_en |=> !tog_q);
  a_r10_disable_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_en |=> !sp_armed);
  a_r9_trailing_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_en && sp_run && fall_t && !sp_go_set) |=> !sp_armed);
  a_r9_idle_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_en && !sp_armed && !sp_run) |-> !gate_final);
endmodule

// File: rtl/tgate_count.sv
module tgate_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_en,
  input  logic             gate_final,
  output logic [CNT_W-1:0] count
);
  logic advance;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic inc);
    return inc ? c + 1'b1 : c;
  endfunction

  assign advance = tick_en & (~gate_en | gate_final);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= step_count(count, advance);
  end

  a_r2_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !gate_en) |=> count == $past(count) + 1'b1);
  a_r3_gate_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en || (gate_en && !gate_final)) |=> $stable(count));
endmodule

// File: rtl/tgate_event.sv
module tgate_event
  import tgate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate_val,
  input  logic irq_clr,
  input  logic irq_en,
  output logic irq_flag,
  output logic irq_req
);
  logic gv_d, gv_fall;

  assign gv_fall = fall_of(gate_val, gv_d);

  // A new event outranks a clear arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gv_d     <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      gv_d <= gate_val;
      if (gv_fall)      irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  assign irq_req = irq_flag & irq_en;

  a_r13_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    gv_fall |=> irq_flag);
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);
  a_r13_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !gv_fall) |=> !irq_flag);
endmodule

// File: rtl/tgate_unit.sv
module tgate_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_pin,
  input  logic [1:0]       cmp_in,
  input  logic [1:0]       cmp_sync_en,
  input  logic [1:0]       gate_src,
  input  logic             gate_inv,
  input  logic             gate_en,
  input  logic             tog_en,
  input  logic             sp_en,
  input  logic             sp_go_set,
  input  logic             irq_clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             gate_val,
  output logic             sp_armed,
  output logic             irq_flag,
  output logic             irq_req
);
  localparam int N_CMP = 2;

  logic [N_CMP-1:0] cmp_q;
  logic             gate_final;

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    tgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cmp_in[i]),
      .sync_en(cmp_sync_en[i]), .q(cmp_q[i])
    );
  end

  tgate_cond u_cond (
    .clk(clk), .rst_n(rst_n), .gate_src(gate_src), .pin(gate_pin),
    .cmp_q(cmp_q), .gate_inv(gate_inv), .tog_en(tog_en), .sp_en(sp_en),
    .sp_go_set(sp_go_set), .gate_final(gate_final), .sp_armed(sp_armed)
  );

  tgate_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_en(gate_en),
    .gate_final(gate_final), .count(count)
  );

  assign gate_val = gate_final;

  tgate_event u_event (
    .clk(clk), .rst_n(rst_n), .gate_val(gate_val), .irq_clr(irq_clr),
    .irq_en(irq_en), .irq_flag(irq_flag), .irq_req(irq_req)
  );

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (count == '0 && !irq_flag && !sp_armed));
endmodule

// File: tb/tgate_unit_bench.sv
module tgate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, gate_pin = 1'b0, gate_inv = 1'b0, gate_en = 1'b0;
  logic [1:0]  cmp_in = '0, cmp_sync_en = '0, gate_src = '0;
  logic        tog_en = 1'b0, sp_en = 1'b0, sp_go_set = 1'b0;
  logic        irq_clr = 1'b0, irq_en = 1'b0;
  logic [15:0] count;
  logic        gate_val, sp_armed, irq_flag, irq_req;
  logic [15:0] base;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tgate_unit u_tgate_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_pin(gate_pin),
    .cmp_in(cmp_in), .cmp_sync_en(cmp_sync_en), .gate_src(gate_src),
    .gate_inv(gate_inv), .gate_en(gate_en), .tog_en(tog_en), .sp_en(sp_en),
    .sp_go_set(sp_go_set), .irq_clr(irq_clr), .irq_en(irq_en),
    .count(count), .gate_val(gate_val), .sp_armed(sp_armed),
    .irq_flag(irq_flag), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int delta();
    return int'(16'(count - base));
  endfunction

  task automatic pin_pulse(input int w, input logic act);
    gate_pin = act; cyc(w); gate_pin = ~act;
  endtask

  task automatic arm();
    sp_go_set = 1'b1; cyc(1); sp_go_set = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 count", count, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 armed", sp_armed, 0);
    rst_n = 1'b1; tick_en = 1'b1;

    // R2 free running and tick_en qualification
    base = count; cyc(10); chk("R2 free run", delta(), 10);
    base = count;
    for (int i = 0; i < 10; i++) begin tick_en = i[0]; cyc(1); end
    tick_en = 1'b1; chk("R2 tick qualified", delta(), 5);

    // R3 gated pin pulses, sweep of widths
    gate_en = 1'b1; cyc(2);
    for (int w = 1; w <= 6; w++) begin
      base = count; pin_pulse(w, 1'b1); cyc(3);
      chk("R3 pulse width", delta(), w);
    end
    base = count; gate_pin = 1'b1;
    for (int i = 0; i < 8; i++) begin tick_en = i[0]; cyc(1); end
    gate_pin = 1'b0; tick_en = 1'b1; cyc(2);
    chk("R3 gate and tick", delta(), 4);

    // R4 inverted polarity
    gate_pin = 1'b1; gate_inv = 1'b1; cyc(2);
    for (int w = 2; w <= 5; w++) begin
      base = count; pin_pulse(w, 1'b0); cyc(3);
      chk("R4 active low", delta(), w);
    end
    gate_pin = 1'b0; gate_inv = 1'b0; cyc(2);

    // R5 source selection, unselected sources ignored
    gate_src = 2'd1; base = count; gate_pin = 1'b1;
    cmp_in[0] = 1'b1; cyc(3); cmp_in[0] = 1'b0; cyc(3);
    chk("R5 cmp A", delta(), 3);
    gate_pin = 1'b0; gate_src = 2'd2; base = count; cmp_in[0] = 1'b1;
    cmp_in[1] = 1'b1; cyc(4); cmp_in[1] = 1'b0; cyc(3);
    chk("R5 cmp B", delta(), 4);
    cmp_in[0] = 1'b0; gate_src = 2'd3; base = count;
    pin_pulse(2, 1'b1); cyc(3); chk("R5 pin alt", delta(), 2);

    // R6 synchronizer latency and count preservation
    gate_src = 2'd1; cmp_sync_en = 2'b01; cyc(3);
    base = count; cmp_in[0] = 1'b1; #1;
    chk("R6 sync same cycle", gate_val, 0);
    cyc(1); chk("R6 sync one edge", gate_val, 0);
    cyc(1); chk("R6 sync two edges", gate_val, 1);
    cyc(3); cmp_in[0] = 1'b0; cyc(5);
    chk("R6 sync count", delta(), 5);
    cmp_sync_en = 2'b00; cyc(1); cmp_in[0] = 1'b1; #1;
    chk("R6 bypass immediate", gate_val, 1);
    cyc(1); cmp_in[0] = 1'b0; gate_src = 2'd0; cyc(2);

    // R7 toggle mode, full periods
    tog_en = 1'b1; cyc(2);
    for (int p = 3; p <= 6; p++) begin
      base = count;
      gate_pin = 1'b1; cyc(1); gate_pin = 1'b0; cyc(p - 1);
      gate_pin = 1'b1; cyc(1); gate_pin = 1'b0; cyc(4);
      chk("R7 period", delta(), p);
    end

    // R8 toggle state cleared while disabled
    gate_pin = 1'b1; cyc(1); gate_pin = 1'b0; cyc(2);
    chk("R7 toggle holds high", gate_val, 1);
    tog_en = 1'b0; cyc(2);
    chk("R8 follows pin", gate_val, 0);
    tog_en = 1'b1; #1;
    chk("R8 restart clear", gate_val, 0);
    tog_en = 1'b0; cyc(2);

    // R9 single pulse
    sp_en = 1'b1; cyc(1); arm();
    chk("R9 armed", sp_armed, 1);
    base = count; pin_pulse(3, 1'b1); cyc(3);
    chk("R9 disarmed", sp_armed, 0);
    pin_pulse(4, 1'b1); cyc(2); pin_pulse(2, 1'b1); cyc(3);
    chk("R9 one pulse", delta(), 3);
    arm(); base = count; pin_pulse(5, 1'b1); cyc(3);
    chk("R9 rearmed", delta(), 5);

    // R10 disabling single pulse disarms
    arm(); chk("R10 armed", sp_armed, 1);
    sp_en = 1'b0; cyc(1); chk("R10 cleared", sp_armed, 0);
    sp_en = 1'b1; cyc(1);
    base = count; pin_pulse(3, 1'b1); cyc(3);
    chk("R10 no count", delta(), 0);

    // R11 toggle plus single pulse: one period
    tog_en = 1'b1; cyc(2); arm(); base = count;
    for (int k = 0; k < 3; k++) begin
      gate_pin = 1'b1; cyc(1); gate_pin = 1'b0; cyc(3);
    end
    cyc(4);
    chk("R11 one period", delta(), 4);
    chk("R11 disarmed", sp_armed, 0);
    tog_en = 1'b0; sp_en = 1'b0; cyc(2);

    // R12 status and flag while gating is off
    gate_en = 1'b0; tick_en = 1'b0;
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    chk("R12 flag cleared", irq_flag, 0);
    gate_pin = 1'b1; #1; chk("R12 live level", gate_val, 1);
    cyc(2); gate_pin = 1'b0; cyc(2);
    chk("R12 flag set ungated", irq_flag, 1);

    // R13 enable, hold, clear, and set-over-clear
    chk("R13 req masked", irq_req, 0);
    irq_en = 1'b1; #1; chk("R13 req on", irq_req, 1);
    cyc(3); chk("R13 sticky", irq_flag, 1);
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    chk("R13 cleared", irq_flag, 0);
    chk("R13 req off", irq_req, 0);
    gate_pin = 1'b1; cyc(3);
    gate_pin = 1'b0; irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    chk("R13 set wins", irq_flag, 1);
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(2);
    chk("R13 clear after", irq_flag, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule